// File: doc/BRIEF.md
# Video Memory Address Mirroring Mapper

This block sits between a picture generator's 14-bit video address bus and its physical storage. Each access is routed by address. The lower 8 KB goes out to an external character memory port. The name table window is folded onto a small internal RAM according to a 2-bit mirroring mode. The palette window is served by a 32-entry palette RAM. That RAM has the expected aliasing between the background-colour slots.

A client presents an address with a read or write strobe. Writes complete at the clock edge. Read data appears on `rdata` in the cycle after the read strobe and stays there until the next read. The external character memory is expected to answer one cycle after `chr_rd`, and its data is passed straight through to `rdata`. The mirroring mode can be changed between any two accesses.

The name table store holds `NT_BANKS` kilobyte banks. With four banks, the four-screen mode gives every logical table its own storage. With two banks, that mode folds the tables onto the low bank bit.

Top module: `vram_map_top`

## Requirements
- R1: Addresses 0x0000–0x1FFF drive the external port: `chr_addr` equals address bits 12:0, `chr_wdata` equals `wdata`, and `chr_rd`/`chr_wr` follow `rd_en`/`wr_en`. Addresses at 0x2000 and above never assert `chr_rd` or `chr_wr`, and an external write changes no internal storage.
- R2: A read of 0x0000–0x1FFF returns `chr_rdata` on `rdata` in the cycle after `rd_en`.
- R3: With `mirror_mode` = 2'b00, logical tables 0 and 1 (0x2000, 0x2400) share storage, tables 2 and 3 (0x2800, 0x2C00) share storage, and the two pairs are distinct.
- R4: With `mirror_mode` = 2'b01, tables 0 and 2 share storage, tables 1 and 3 share storage, and the two pairs are distinct.
- R5: With `mirror_mode` = 2'b10, all four tables share one kilobyte of storage.
- R6: With `mirror_mode` = 2'b11 and four banks, each table has separate storage, including its attribute bytes at offsets 0x3C0–0x3FF.
- R7: Addresses 0x3000–0x3EFF reach the same storage as the address 0x1000 lower.
- R8: The palette holds 32 locations at 0x3F00–0x3F1F, and 0x3F20–0x3FFF repeat them with period 32 (index = address bits 4:0).
- R9: Every palette index whose bits 1:0 are zero (0x00, 0x04, … 0x1C) refers to one shared location. Other indices are distinct.
- R10: A palette write keeps only `wdata` bits 5:0. A palette read returns 0 in bits 7:6.
- R11: Internal reads return data in the cycle after `rd_en`. `rdata` then holds until the next read, including across writes.
- R12: After reset and before the first read, `rdata` is 0 and both character strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 14 | Video memory address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| mirror_mode | input | 2 | 00 horizontal, 01 vertical, 10 single, 11 four-screen |
| rdata | output | 8 | Read data, one cycle after `rd_en` |
| chr_addr | output | 13 | External character memory address |
| chr_rd | output | 1 | External read strobe |
| chr_wr | output | 1 | External write strobe |
| chr_wdata | output | 8 | External write data |
| chr_rdata | input | 8 | External read data, one cycle after `chr_rd` |

## Verification
The bench builds the block with its default of four name table banks. This makes the four-screen mode fully distinct and lets all four mirroring modes be exercised against one instance. The alias checks write a marker to one address after clearing another, then read the second. This separates shared from distinct storage in every mode, across the 0x3000 window and across the palette mirrors and colour-0 slots.

// File: rtl/vram_map_pkg.sv
package vram_map_pkg;
  typedef enum logic [1:0] {
    RGN_IDLE = 2'd0,
    RGN_CHR  = 2'd1,
    RGN_NT   = 2'd2,
    RGN_PAL  = 2'd3
  } rgn_t;

  typedef enum logic [1:0] {
    MIR_HORZ   = 2'd0,
    MIR_VERT   = 2'd1,
    MIR_SINGLE = 2'd2,
    MIR_FOUR   = 2'd3
  } mir_t;
endpackage

// File: rtl/vram_sp_ram.sv
module vram_sp_ram #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end

  assign rdata = q;
endmodule

// File: rtl/vram_decode.sv
module vram_decode
  import vram_map_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic [13:0]          addr,
  input  mir_t                 mode,
  output rgn_t                 region,
  output logic [BANK_W+9:0]    nt_addr,
  output logic [4:0]           pal_addr
);
  logic [1:0] tbl;
  logic [1:0] bank_full;

  assign tbl = addr[11:10];

  always_comb begin
    if (!addr[13])                region = RGN_CHR;
    else if (addr[13:8] == 6'h3F) region = RGN_PAL;
    else                          region = RGN_NT;
  end

  always_comb begin
    unique case (mode)
      MIR_HORZ:   bank_full = {1'b0, tbl[1]};
      MIR_VERT:   bank_full = {1'b0, tbl[0]};
      MIR_SINGLE: bank_full = 2'b00;
      default:    bank_full = tbl;
    endcase
  end

  generate
    if (BANK_W >= 2) begin : g_four
      assign nt_addr = {bank_full, addr[9:0]};
    end else begin : g_two
      assign nt_addr = {bank_full[0], addr[9:0]};
    end
  endgenerate

  assign pal_addr = (addr[1:0] == 2'b00) ? 5'd0 : addr[4:0];
endmodule

// File: rtl/vram_map_top.sv
module vram_map_top
  import vram_map_pkg::*;
#(
  parameter int NT_BANKS = 4,
  parameter int PAL_BITS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  input  logic [1:0]  mirror_mode,
  output logic [7:0]  rdata,
  output logic [12:0] chr_addr,
  output logic        chr_rd,
  output logic        chr_wr,
  output logic [7:0]  chr_wdata,
  input  logic [7:0]  chr_rdata
);
  localparam int BANK_W = (NT_BANKS > 2) ? 2 : 1;
  localparam int NT_AW  = BANK_W + 10;

  rgn_t               region;
  rgn_t               region_q;
  rgn_t               region_d;
  logic [NT_AW-1:0]   nt_addr;
  logic [4:0]         pal_ram_addr;
  logic               nt_en, nt_we, pal_en, pal_we;
  logic [7:0]         nt_q;
  logic [PAL_BITS-1:0] pal_q;

  vram_decode #(.BANK_W(BANK_W)) u_dec (
    .addr     (addr),
    .mode     (mir_t'(mirror_mode)),
    .region   (region),
    .nt_addr  (nt_addr),
    .pal_addr (pal_ram_addr)
  );

  assign nt_en  = (rd_en | wr_en) & (region == RGN_NT);
  assign nt_we  = wr_en & (region == RGN_NT);
  assign pal_en = (rd_en | wr_en) & (region == RGN_PAL);
  assign pal_we = wr_en & (region == RGN_PAL);

  vram_sp_ram #(.DW(8), .AW(NT_AW)) u_nt_ram (
    .clk   (clk),
    .en    (nt_en),
    .we    (nt_we),
    .addr  (nt_addr),
    .wdata (wdata),
    .rdata (nt_q)
  );

  vram_sp_ram #(.DW(PAL_BITS), .AW(5)) u_pal_ram (
    .clk   (clk),
    .en    (pal_en),
    .we    (pal_we),
    .addr  (pal_ram_addr),
    .wdata (wdata[PAL_BITS-1:0]),
    .rdata (pal_q)
  );

  assign chr_addr  = addr[12:0];
  assign chr_wdata = wdata;
  assign chr_rd    = rd_en & (region == RGN_CHR);
  assign chr_wr    = wr_en & (region == RGN_CHR);

  // source of the pending read: next-state and register
  always_comb begin
    region_d = region_q;
    if (rd_en) region_d = region;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) region_q <= RGN_IDLE;
    else        region_q <= region_d;
  end

  always_comb begin
    unique case (region_q)
      RGN_CHR: rdata = chr_rdata;
      RGN_NT:  rdata = nt_q;
      RGN_PAL: rdata = {{(8-PAL_BITS){1'b0}}, pal_q};
      default: rdata = 8'h00;
    endcase
  end

  // R1
  chr_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_wr || chr_rd) |-> !(nt_en || pal_en));
  // R2
  chr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_q == RGN_CHR) |-> (rdata == chr_rdata));
  // R9
  pal_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_en && addr[1:0] == 2'b00) |-> (pal_ram_addr == 5'd0));
  // R10
  pal_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_q == RGN_PAL) |-> (rdata[7:6] == 2'b00));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && region_q != RGN_CHR) |=> $stable(rdata));
  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region_q == RGN_IDLE) |-> (rdata == 8'h00));
endmodule

// File: tb/vram_map_top_tb.sv
module vram_map_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] addr;
  logic        rd_en, wr_en;
  logic [7:0]  wdata;
  logic [1:0]  mirror_mode;
  logic [7:0]  rdata;
  logic [12:0] chr_addr;
  logic        chr_rd, chr_wr;
  logic [7:0]  chr_wdata;
  logic [7:0]  chr_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vram_map_top u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .mirror_mode(mirror_mode), .rdata(rdata),
    .chr_addr(chr_addr), .chr_rd(chr_rd), .chr_wr(chr_wr),
    .chr_wdata(chr_wdata), .chr_rdata(chr_rdata)
  );

  // external character memory model: data is a function of address
  always_ff @(posedge clk) if (chr_rd) chr_rdata <= chr_addr[7:0] ^ 8'h5A;

  // vector: mode[47:46] wa[45:32] ra[31:18] d[17:10] alias[9] tag[7:0]
  localparam int NV = 21;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 14'h2400, 14'h2000, 8'h11, 1'b1, 1'b0, 8'd3},  // R3
    {2'd0, 14'h2C05, 14'h2805, 8'h12, 1'b1, 1'b0, 8'd3},  // R3
    {2'd0, 14'h2800, 14'h2000, 8'h13, 1'b0, 1'b0, 8'd3},  // R3
    {2'd1, 14'h2800, 14'h2000, 8'h21, 1'b1, 1'b0, 8'd4},  // R4
    {2'd1, 14'h2C10, 14'h2410, 8'h22, 1'b1, 1'b0, 8'd4},  // R4
    {2'd1, 14'h2400, 14'h2000, 8'h23, 1'b0, 1'b0, 8'd4},  // R4
    {2'd2, 14'h2C33, 14'h2033, 8'h31, 1'b1, 1'b0, 8'd5},  // R5
    {2'd2, 14'h2733, 14'h2B33, 8'h32, 1'b1, 1'b0, 8'd5},  // R5
    {2'd3, 14'h2400, 14'h2000, 8'h41, 1'b0, 1'b0, 8'd6},  // R6
    {2'd3, 14'h2C00, 14'h2800, 8'h42, 1'b0, 1'b0, 8'd6},  // R6
    {2'd3, 14'h27C4, 14'h2FC4, 8'h43, 1'b0, 1'b0, 8'd6},  // R6
    {2'd0, 14'h3123, 14'h2123, 8'h51, 1'b1, 1'b0, 8'd7},  // R7
    {2'd0, 14'h3E80, 14'h2E80, 8'h52, 1'b1, 1'b0, 8'd7},  // R7
    {2'd0, 14'h3F25, 14'h3F05, 8'h61, 1'b1, 1'b0, 8'd8},  // R8
    {2'd0, 14'h3FE7, 14'h3F07, 8'h62, 1'b1, 1'b0, 8'd8},  // R8
    {2'd0, 14'h3F01, 14'h3F11, 8'h63, 1'b0, 1'b0, 8'd8},  // R8
    {2'd0, 14'h3F10, 14'h3F00, 8'h71, 1'b1, 1'b0, 8'd9},  // R9
    {2'd0, 14'h3F04, 14'h3F1C, 8'h72, 1'b1, 1'b0, 8'd9},  // R9
    {2'd0, 14'h3F14, 14'h3F08, 8'h73, 1'b1, 1'b0, 8'd9},  // R9
    {2'd0, 14'h3F05, 14'h3F01, 8'h74, 1'b0, 1'b0, 8'd9},  // R9
    {2'd0, 14'h3F02, 14'h3F02, 8'hFF, 1'b1, 1'b0, 8'd10}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic       wr_chr_seen;
  logic [12:0] wr_chr_addr;
  logic [7:0] wr_chr_data;

  task automatic do_write(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    #1;
    wr_chr_seen = chr_wr; wr_chr_addr = chr_addr; wr_chr_data = chr_wdata;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [13:0] a, output logic [7:0] d, output logic rd_strobe);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    rd_strobe = chr_rd;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic s;
    rst_n = 1'b0; addr = '0; rd_en = 0; wr_en = 0; wdata = '0; mirror_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 rdata", rdata, 8'h00);
    check("R12 strobes", {chr_rd, chr_wr}, 2'b00);

    // table-driven alias vectors
    for (int i = 0; i < NV; i++) begin
      logic [13:0] wa, ra;
      logic [7:0]  dv, exp;
      mirror_mode = VEC[i][47:46];
      wa = VEC[i][45:32]; ra = VEC[i][31:18]; dv = VEC[i][17:10];
      do_write(ra, 8'h00);
      do_write(wa, dv);
      do_read(ra, d, s);
      if (!VEC[i][9])          exp = 8'h00;
      else if (ra[13:8] == 6'h3F) exp = {2'b00, dv[5:0]};
      else                      exp = dv;
      check($sformatf("R%0d vec%0d", VEC[i][7:0], i), d, exp);
    end

    // R1 external write: strobe, address and data pass out
    do_write(14'h1234, 8'hA7);
    check("R1 chr_wr", wr_chr_seen, 1'b1);
    check("R1 chr_addr", wr_chr_addr, 13'h1234);
    check("R1 chr_wdata", wr_chr_data, 8'hA7);
    // R1 internal write keeps external port quiet
    do_write(14'h2345, 8'h5C);
    check("R1 no chr_wr internal", wr_chr_seen, 1'b0);
    do_write(14'h3F09, 8'h15);
    check("R1 no chr_wr palette", wr_chr_seen, 1'b0);
    // R1 external write at a low-bit alias of 0x2345 leaves it intact
    do_write(14'h0345, 8'hEE);
    do_read(14'h2345, d, s);
    check("R1 nt untouched", d, 8'h5C);
    check("R1 no chr_rd internal", s, 1'b0);

    // R2 external read
    do_read(14'h0ABC, d, s);
    check("R2 chr_rd", s, 1'b1);
    check("R2 rdata", d, 8'hBC ^ 8'h5A);
    do_read(14'h1F01, d, s);
    check("R2 rdata hi", d, 8'h01 ^ 8'h5A);

    // R11 hold after read, through idle cycles and a write
    do_read(14'h2345, d, s);
    repeat (3) @(negedge clk);
    check("R11 hold idle", rdata, 8'h5C);
    do_write(14'h2345, 8'h99);
    check("R11 hold across write", rdata, 8'h5C);
    do_read(14'h2345, d, s);
    check("R11 new read", d, 8'h99);

    // R8 all 32 palette locations through rotating mirrors
    for (int i = 1; i < 32; i++)
      if (i % 4 != 0) do_write(14'h3F00 + 14'(i), 8'(i + 8'h20));
    do_write(14'h3F00, 8'h3E);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] exp;
      exp = (i % 4 == 0) ? 8'h3E : 8'(i + 8'h20);
      do_read(14'h3F00 + 14'((i % 7) * 32 + i), d, s);
      check($sformatf("R8 pal idx %0d", i), d, exp);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule